// File: doc/BRIEF.md
# Sector Lock Value Serial Read Port

This block is the serial-slave front end of a flash memory that answers one command: reading back the lock byte of a sector. It oversamples chip select, the serial clock and the serial data input with the system clock. It detects serial clock edges, shifts in an 8-bit command code and a 24-bit address, and picks the 8-bit lock value of the addressed sector from a flat table input. It then drives that value on the serial data output.

Command and address bits are taken on rising serial clock edges, and output bits change on falling edges. The output is enabled only once the full address has arrived. Chip select going high ends the transfer at any point and releases the output at once. A command that arrives while the program/erase engine reports busy is rejected: nothing is driven, and the engine is not touched. Bit 0 of each lock byte is the write-lock flag and bit 1 is the lock-down flag; the block passes the byte through unchanged.

Top module: `lock_reg_reader`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `miso_oe` is 0.
- R2: The command code is 8 bits, MSB first, sampled on rising `sck` edges after `cs_n` falls. Only code 0xE8 is served. Any other code leaves `miso_oe` at 0 until `cs_n` rises again.
- R3: The 24-bit address (A23 first) follows the code. Bits A21..A16 form the sector index, and all other address bits have no effect on the returned value.
- R4: `miso_oe` stays 0 until the first falling `sck` edge after the rising edge that carries A0.
- R5: On that falling edge, `miso` carries bit 7 of the lock byte. Each further falling edge presents the next lower bit, and `miso` holds its value between falling edges.
- R6: After bit 0, the same byte repeats from bit 7 for as long as `cs_n` stays low.
- R7: Raising `cs_n` at any point, including mid-byte during data output, drops `miso_oe` to 0 combinationally and restarts command capture for the next transaction.
- R8: If `busy` is 1 on the rising edge that completes the command code, the command is rejected and `miso_oe` stays 0 for the rest of the transaction.
- R9: The lock byte for sector s is `lock_tbl[8*s+7 : 8*s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in (command and address) |
| busy | input | 1 | Program/erase cycle in progress |
| lock_tbl | input | 512 | Lock bytes of all 64 sectors, sector s at bits 8s+7..8s |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
A miscounted bit counter or a wrong shift position shows up at the ports within one transaction. Either the enable rises one serial clock early or late, or the byte that appears belongs to a neighbouring sector or is rotated by a bit. The bench reads every sector and compares the 16 bits that follow the address against arithmetically generated table contents. It also probes the enable just before and just after the edge where it must rise, so such a fault is seen within a few system clocks. A stuck phase after an abort or a rejected command would show as a missing or spurious enable in the very next transaction, which the bench runs straight after each abort and each rejection.

// File: rtl/lock_reg_reader.sv
module lock_reg_reader #(
  parameter int SEC_W     = 6,
  parameter int SEC_LO    = 16,
  parameter int DW        = 8,
  parameter int ADDR_BITS = 24,
  parameter logic [7:0] RD_CODE = 8'hE8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         sck,
  input  logic                         mosi,
  input  logic                         busy,
  input  logic [(1<<SEC_W)*DW-1:0]     lock_tbl,
  output logic                         miso,
  output logic                         miso_oe
);
  localparam int TOTAL = 8 + ADDR_BITS;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int IW    = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [1:0] {S_CMD, S_ADDR, S_DATA, S_DROP} ph_t;

  ph_t                  phase;
  logic                 sck_q;
  logic [CW-1:0]        cnt;
  logic [ADDR_BITS-1:0] sh;
  logic [DW-1:0]        val;
  logic [IW-1:0]        idx;
  logic                 oe_q, miso_q;

  wire rise = sck & ~sck_q;
  wire fall = ~sck & sck_q;

  wire [ADDR_BITS-1:0] sh_nxt  = {sh[ADDR_BITS-2:0], mosi};
  wire [SEC_W-1:0]     sec_nxt = sh_nxt[SEC_LO +: SEC_W];
  wire                 code_ok = (sh_nxt[7:0] == RD_CODE);

  assign miso    = miso_q;
  assign miso_oe = oe_q & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= S_CMD;
      cnt    <= '0;
      sh     <= '0;
      val    <= '0;
      idx    <= IW'(DW - 1);
      oe_q   <= 1'b0;
      miso_q <= 1'b0;
    end else if (cs_n) begin
      phase <= S_CMD;
      cnt   <= '0;
      idx   <= IW'(DW - 1);
      oe_q  <= 1'b0;
    end else begin
      case (phase)
        S_CMD: if (rise) begin
          sh  <= sh_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7))
            phase <= (code_ok && !busy) ? S_ADDR : S_DROP;
        end
        S_ADDR: if (rise) begin
          sh  <= sh_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(TOTAL - 1)) begin
            val   <= lock_tbl[int'(sec_nxt)*DW +: DW];
            phase <= S_DATA;
          end
        end
        S_DATA: if (fall) begin
          oe_q   <= 1'b1;
          miso_q <= val[idx];
          idx    <= (idx == '0) ? IW'(DW - 1) : idx - 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_oe_off_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso_oe);

  p_no_oe_before_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != S_DATA) |-> !oe_q);

  p_reject_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == S_CMD && cnt == CW'(7) && rise && busy) |=> (phase == S_DROP || cs_n));

  p_drop_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_DROP) |-> !miso_oe);

  p_hold_between_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !cs_n) |=> $stable(miso_q));

endmodule

// File: tb/lock_reg_reader_test.sv
module lock_reg_reader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic [511:0] tbl;
  logic miso, miso_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lock_reg_reader uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
                       .busy(busy), .lock_tbl(tbl), .miso(miso), .miso_oe(miso_oe));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi = b; wait_n(4);
    sck = 1'b1; wait_n(4);
    sck = 1'b0; wait_n(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // sends address; checks R4 around the A0 rising edge and returns first data bit
  task automatic send_addr(input logic [23:0] a, output logic first_bit);
    for (int i = 23; i >= 1; i--) send_bit(a[i]);
    mosi = a[0]; wait_n(4);
    sck = 1'b1; wait_n(4);
    chk("R4 oe low before first data fall", {15'd0, miso_oe}, 16'd0);
    sck = 1'b0; wait_n(4);
    chk("R4 oe high after first data fall", {15'd0, miso_oe}, 16'd1);
    first_bit = miso;
  endtask

  task automatic read_bits(input int n, input logic fb, output logic [15:0] got);
    got = '0;
    got[15] = fb;
    for (int i = 1; i < n; i++) begin
      sck = 1'b1; wait_n(4);
      sck = 1'b0; wait_n(4);
      got[15-i] = miso;
    end
  endtask

  task automatic end_tx;
    cs_n = 1'b1; wait_n(4);
  endtask

  function automatic logic [7:0] entry(input int s);
    return 8'((s * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic fb;
    logic [15:0] got;
    for (int s = 0; s < 64; s++) tbl[s*8 +: 8] = entry(s);
    wait_n(3);
    chk("R1 oe low in reset", {15'd0, miso_oe}, 16'd0);
    rst_n = 1'b1; wait_n(3);
    chk("R1 oe low idle cs high", {15'd0, miso_oe}, 16'd0);

    // R9/R5/R6 sweep of all sectors
    for (int s = 0; s < 64; s++) begin
      logic [23:0] a;
      a = {2'(s), 6'(s), 16'((s * 1234 + 7) & 16'hFFFF)};
      cs_n = 1'b0; wait_n(4);
      send_byte(8'hE8);
      send_addr(a, fb);
      read_bits(16, fb, got);
      chk("R5 R9 first byte MSB first", {8'd0, got[15:8]}, {8'd0, entry(s)});
      chk("R6 repeat byte", {8'd0, got[7:0]}, {8'd0, entry(s)});
      end_tx();
      chk("R1 oe low after cs high", {15'd0, miso_oe}, 16'd0);
    end

    // R3: other address bits ignored
    for (int s = 0; s < 64; s += 9) begin
      cs_n = 1'b0; wait_n(4);
      send_byte(8'hE8);
      send_addr({~2'(s), 6'(s), ~16'(s * 77)}, fb);
      read_bits(8, fb, got);
      chk("R3 only A21..A16 select", {8'd0, got[15:8]}, {8'd0, entry(s)});
      end_tx();
    end

    // R2: wrong codes
    for (int c = 0; c < 256; c += 17) begin
      if (8'(c) == 8'hE8) continue;
      cs_n = 1'b0; wait_n(4);
      send_byte(8'(c));
      for (int i = 0; i < 40; i++) send_bit(1'b1);
      chk("R2 wrong code no output", {15'd0, miso_oe}, 16'd0);
      end_tx();
    end

    // R8: busy rejects
    busy = 1'b1;
    cs_n = 1'b0; wait_n(4);
    send_byte(8'hE8);
    busy = 1'b0;
    for (int i = 0; i < 40; i++) send_bit(1'b0);
    chk("R8 busy rejected no output", {15'd0, miso_oe}, 16'd0);
    end_tx();

    // R7: abort mid-byte, then fresh transaction
    cs_n = 1'b0; wait_n(4);
    send_byte(8'hE8);
    send_addr({8'h00, 16'h0000} | (24'd5 << 16), fb);
    read_bits(3, fb, got);
    chk("R7 abort sees partial bits", {13'd0, got[15:13]}, {13'd0, entry(5) >> 5});
    cs_n = 1'b1; #1;
    chk("R7 oe drops at once", {15'd0, miso_oe}, 16'd0);
    wait_n(4);
    cs_n = 1'b0; wait_n(4);
    send_byte(8'hE8);
    send_addr(24'd63 << 16, fb);
    read_bits(8, fb, got);
    chk("R7 fresh transaction after abort", {8'd0, got[15:8]}, {8'd0, entry(63)});
    end_tx();

    // R7: abort during address, then retry
    cs_n = 1'b0; wait_n(4);
    send_byte(8'hE8);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    end_tx();
    cs_n = 1'b0; wait_n(4);
    send_byte(8'hE8);
    send_addr(24'd17 << 16, fb);
    read_bits(8, fb, got);
    chk("R7 retry after address abort", {8'd0, got[15:8]}, {8'd0, entry(17)});
    end_tx();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule